// File: doc/BRIEF.md
# Root Clock Generator with Fractional M/N Divider

This block derives a slower clock from one of two source clocks. Both sources reach it as single-cycle enable strobes in one system clock domain, so the whole design runs on a single clock. A pre-divider, which can divide in half steps, thins the selected strobe stream into ticks. An optional M/N accumulator can then pass exactly M of every N ticks. The result leaves the block as a one-cycle clock-enable pulse and as a level signal. The duty of the level signal comes from a programmed D value.

Software reaches five 32-bit registers over a word-addressed bus with a write strobe and combinational read data. These are configuration, command, M, N and D. Writes land only in shadow copies. To apply them, software sets the update bit in the command register. The block waits for the next pre-divider tick, copies the shadow values into its active state in a single step, clears the bit one cycle later, and software polls until the bit reads zero.

Top module: `rcg_mnd_top`

## Requirements
- R1: After reset, all five registers read zero and both outputs are low. The active state selects the reference source at divide-by-1 with the counter bypassed, so each reference strobe gives one enable pulse.
- R2: In the configuration register, bits 4:0 hold the pre-divide field, bits 10:8 the source code and bits 13:12 the counter mode. Only bits 13:0 are stored. Bits 31:14 read back as zero.
- R3: Source code 0 selects the reference strobe and code 1 the PLL strobe. The strobe that is not selected has no effect. Codes 2 to 7 select nothing, so no enable pulses occur.
- R4: A pre-divide field value f divides the selected strobe rate by (f+1)/2, so 7 means divide by 4 and 2 means divide by 1.5. A value of 0 acts as 1. With the counter bypassed, every pre-divided tick gives one enable pulse.
- R5: The counter runs only when the mode field is 2 and the N register is nonzero. Its modulus is N = NOT(Nreg) + M (16 bits). When M < N it gives exactly M enable pulses in any N consecutive ticks. Any other mode, or an N register of zero, bypasses it.
- R6: The level output takes 2D = NOT(Dreg). In counter mode, after each tick the level is high when twice the accumulator value is below 2D. Over N ticks with M and N coprime, it is high for ceil(2D/2) ticks. In bypass mode the level equals the enable output.
- R7: Writes to the configuration, M, N or D registers do not change the outputs until an update is applied.
- R8: Writing 1 to bit 0 of the command register (offset 0x4) sets the update bit. The active state loads on the next pre-divided tick, or at once when the active source code is reserved. The bit reads zero from the second cycle after the load. With strobes present every cycle, that is at most ceil((f+1)/2)+4 cycles after the write.
- R9: The enable output rises in the cycle after the clock edge that samples the strobe causing it, and lasts one cycle.
- R10: The byte offsets are 0x0 configuration, 0x4 command, 0x8 M, 0xC N and 0x10 D. The M, N and D registers store the low 16 bits written, and their upper bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_stb_i | input | 1 | Reference source strobe |
| pll_stb_i | input | 1 | PLL source strobe |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 5 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data (combinational) |
| clk_en_o | output | 1 | Divided clock-enable pulse |
| clk_lvl_o | output | 1 | Duty-shaped level output |

## Verification
Read data is combinational, so the bench reads a register a moment after it sets the address at a falling edge. A strobe driven at one falling edge is sampled at the next rising edge and shows up on both outputs after that edge. The bench therefore reads the outputs at the following falling edge and credits the result to the strobe before it. Pulse counts are taken over windows whose number of selected strobes makes the tick count an exact multiple of both the pre-divide ratio and N. Because of this, the unknown divider phase at the start of a window cannot change the expected count. The update latency is the number of falling edges that pass, with strobes running every cycle, until the command bit reads zero. It is compared with the bound in R8.

// File: rtl/rcg_pkg.sv
package rcg_pkg;
  localparam int DIV_W  = 5;
  localparam int SRC_W  = 3;
  localparam int MODE_W = 2;
  localparam int CFG_W  = 14;
  localparam int AW     = 5;

  localparam int CFG_DIV_LSB  = 0;
  localparam int CFG_SRC_LSB  = 8;
  localparam int CFG_MODE_LSB = 12;

  localparam logic [SRC_W-1:0]  SRC_REF   = 3'd0;
  localparam logic [SRC_W-1:0]  SRC_PLL   = 3'd1;
  localparam logic [MODE_W-1:0] MODE_DUAL = 2'd2;

  localparam logic [AW-1:0] OFF_CFG = 5'h00;
  localparam logic [AW-1:0] OFF_CMD = 5'h04;
  localparam logic [AW-1:0] OFF_M   = 5'h08;
  localparam logic [AW-1:0] OFF_N   = 5'h0C;
  localparam logic [AW-1:0] OFF_D   = 5'h10;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SRC_W-1:0]  src;
    logic [DIV_W-1:0]  div;
  } rcg_cfg_t;

  function automatic rcg_cfg_t cfg_unpack(input logic [CFG_W-1:0] raw);
    rcg_cfg_t c;
    c.div  = raw[CFG_DIV_LSB  +: DIV_W];
    c.src  = raw[CFG_SRC_LSB  +: SRC_W];
    c.mode = raw[CFG_MODE_LSB +: MODE_W];
    return c;
  endfunction
endpackage

// File: rtl/rcg_regs.sv
module rcg_regs
  import rcg_pkg::*;
#(
  parameter int MND_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              boundary,
  output logic              load,
  output rcg_cfg_t          act_cfg,
  output logic [MND_W-1:0]  act_m,
  output logic [MND_W-1:0]  act_n,
  output logic [MND_W-1:0]  act_twod,
  output logic              act_cnt_en
);
  localparam int PAD_CFG = DATA_W - CFG_W;
  localparam int PAD_MND = DATA_W - MND_W;

  logic [CFG_W-1:0] cfg_q, cfg_d;
  logic [MND_W-1:0] m_q, m_d, n_q, n_d, d_q, d_d;
  logic             cmd_q, cmd_d, loaded_q;
  rcg_cfg_t         act_cfg_d, sh_cfg;
  logic [MND_W-1:0] act_m_d, act_n_d, act_twod_d;
  logic             act_cnt_en_d;

  assign sh_cfg = cfg_unpack(cfg_q);
  assign load   = cmd_q & boundary & ~loaded_q;

  // shadow register write path
  always_comb begin
    cfg_d = cfg_q;
    m_d   = m_q;
    n_d   = n_q;
    d_d   = d_q;
    cmd_d = cmd_q;
    if (loaded_q) cmd_d = 1'b0;
    if (wr_en) begin
      unique case (addr)
        OFF_CFG: cfg_d = wdata[CFG_W-1:0];
        OFF_CMD: if (wdata[0]) cmd_d = 1'b1;
        OFF_M:   m_d   = wdata[MND_W-1:0];
        OFF_N:   n_d   = wdata[MND_W-1:0];
        OFF_D:   d_d   = wdata[MND_W-1:0];
        default: ;
      endcase
    end
  end

  // active state: loaded in one step on an accepted update
  always_comb begin
    act_cfg_d    = act_cfg;
    act_m_d      = act_m;
    act_n_d      = act_n;
    act_twod_d   = act_twod;
    act_cnt_en_d = act_cnt_en;
    if (load) begin
      act_cfg_d    = sh_cfg;
      act_m_d      = m_q;
      act_n_d      = ~n_q + m_q;
      act_twod_d   = ~d_q;
      act_cnt_en_d = (sh_cfg.mode == MODE_DUAL) && (n_q != '0);
    end
  end

  always_comb begin
    unique case (addr)
      OFF_CFG: rdata = {{PAD_CFG{1'b0}}, cfg_q};
      OFF_CMD: rdata = {{(DATA_W-1){1'b0}}, cmd_q};
      OFF_M:   rdata = {{PAD_MND{1'b0}}, m_q};
      OFF_N:   rdata = {{PAD_MND{1'b0}}, n_q};
      OFF_D:   rdata = {{PAD_MND{1'b0}}, d_q};
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      m_q        <= '0;
      n_q        <= '0;
      d_q        <= '0;
      cmd_q      <= 1'b0;
      loaded_q   <= 1'b0;
      act_cfg    <= '0;
      act_m      <= '0;
      act_n      <= '0;
      act_twod   <= '0;
      act_cnt_en <= 1'b0;
    end else begin
      cfg_q      <= cfg_d;
      m_q        <= m_d;
      n_q        <= n_d;
      d_q        <= d_d;
      cmd_q      <= cmd_d;
      loaded_q   <= load;
      act_cfg    <= act_cfg_d;
      act_m      <= act_m_d;
      act_n      <= act_n_d;
      act_twod   <= act_twod_d;
      act_cnt_en <= act_cnt_en_d;
    end
  end

  assert_cmd_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_q) |-> $past(load, 2));
  assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
  assert_cfg_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFF_CFG) |-> (rdata[DATA_W-1:CFG_W] == '0));
endmodule

// File: rtl/rcg_prediv.sv
module rcg_prediv
  import rcg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_stb,
  input  logic             pll_stb,
  input  logic [SRC_W-1:0] src,
  input  logic [DIV_W-1:0] div,
  input  logic             clear,
  output logic             tick,
  output logic             src_ok
);
  localparam int ACC_W = DIV_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, lim, sum;
  logic             sel_stb;

  always_comb begin
    unique case (src)
      SRC_REF: begin sel_stb = ref_stb; src_ok = 1'b1; end
      SRC_PLL: begin sel_stb = pll_stb; src_ok = 1'b1; end
      default: begin sel_stb = 1'b0;    src_ok = 1'b0; end
    endcase
  end

  // ratio (div+1)/2 tracked in half-strobe units
  assign lim = (div == '0) ? ACC_W'(2) : ({1'b0, div} + ACC_W'(1));
  assign sum = acc_q + ACC_W'(2);

  always_comb begin
    acc_d = acc_q;
    tick  = 1'b0;
    if (sel_stb) begin
      if (sum >= lim) begin
        tick  = 1'b1;
        acc_d = sum - lim;
      end else begin
        acc_d = sum;
      end
    end
    if (clear) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assert_prediv_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < lim);
  assert_tick_needs_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (src == SRC_REF ? ref_stb : pll_stb));
endmodule

// File: rtl/rcg_mnd.sv
module rcg_mnd #(
  parameter int MND_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             clear,
  input  logic             cnt_en,
  input  logic [MND_W-1:0] m,
  input  logic [MND_W-1:0] n,
  input  logic [MND_W-1:0] twod,
  output logic             en_o,
  output logic             lvl_o
);
  localparam int SUM_W = MND_W + 1;

  logic [MND_W-1:0] acc_q, acc_d, step;
  logic [SUM_W-1:0] sum, diff;
  logic             wrap, en_d, lvl_d;

  assign sum  = {1'b0, acc_q} + {1'b0, m};
  assign diff = sum - {1'b0, n};
  assign wrap = (sum >= {1'b0, n});
  assign step = wrap ? diff[MND_W-1:0] : sum[MND_W-1:0];

  always_comb begin
    acc_d = acc_q;
    en_d  = 1'b0;
    lvl_d = cnt_en ? lvl_o : 1'b0;
    if (tick) begin
      if (cnt_en) begin
        acc_d = step;
        en_d  = wrap;
        lvl_d = ({step, 1'b0} < {1'b0, twod});
      end else begin
        en_d  = 1'b1;
        lvl_d = 1'b1;
      end
    end
    if (clear) acc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      en_o  <= 1'b0;
      lvl_o <= 1'b0;
    end else begin
      acc_q <= acc_d;
      en_o  <= en_d;
      lvl_o <= lvl_d;
    end
  end

  assert_acc_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && (m < n)) |-> (acc_q < n));
  assert_bypass_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !$past(cnt_en)) |-> (lvl_o == en_o));
endmodule

// File: rtl/rcg_mnd_top.sv
module rcg_mnd_top
  import rcg_pkg::*;
#(
  parameter int MND_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_stb_i,
  input  logic              pll_stb_i,
  input  logic              bus_we_i,
  input  logic [AW-1:0]     bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              clk_en_o,
  output logic              clk_lvl_o
);
  logic [1:0]       rsync_q;
  logic             rst_n_s;
  logic             tick_w, src_ok_w, load_w, cnt_en_w;
  rcg_cfg_t         act_cfg_w;
  logic [MND_W-1:0] act_m_w, act_n_w, act_twod_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n_s = rsync_q[1];

  rcg_regs #(.MND_W(MND_W), .DATA_W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_en      (bus_we_i),
    .addr       (bus_addr_i),
    .wdata      (bus_wdata_i),
    .rdata      (bus_rdata_o),
    .boundary   (tick_w | ~src_ok_w),
    .load       (load_w),
    .act_cfg    (act_cfg_w),
    .act_m      (act_m_w),
    .act_n      (act_n_w),
    .act_twod   (act_twod_w),
    .act_cnt_en (cnt_en_w)
  );

  rcg_prediv u_prediv (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .ref_stb (ref_stb_i),
    .pll_stb (pll_stb_i),
    .src     (act_cfg_w.src),
    .div     (act_cfg_w.div),
    .clear   (load_w),
    .tick    (tick_w),
    .src_ok  (src_ok_w)
  );

  rcg_mnd #(.MND_W(MND_W)) u_mnd (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick   (tick_w),
    .clear  (load_w),
    .cnt_en (cnt_en_w),
    .m      (act_m_w),
    .n      (act_n_w),
    .twod   (act_twod_w),
    .en_o   (clk_en_o),
    .lvl_o  (clk_lvl_o)
  );

  assert_enable_after_tick_R9: assert property (@(posedge clk) disable iff (!rst_n_s)
    clk_en_o |-> $past(tick_w));
  assert_no_out_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!src_ok_w && !$past(load_w)) |-> !clk_en_o);
endmodule

// File: tb/rcg_mnd_top_tb.sv
`timescale 1ns/1ps
module rcg_mnd_top_tb;
  import rcg_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n, ref_stb, pll_stb, we;
  logic [4:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        en, lvl;
  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  rcg_mnd_top u_dut (
    .clk(clk), .rst_n(rst_n), .ref_stb_i(ref_stb), .pll_stb_i(pll_stb),
    .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .clk_en_o(en), .clk_lvl_o(lvl)
  );

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lim_of(input int f);
    return (f == 0) ? 2 : f + 1;
  endfunction

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  // R8: request update, run both strobes every cycle, poll until clear
  task automatic do_update(input int old_f);
    int cyc = 0;
    bit done = 1'b0;
    bus_wr(OFF_CMD, 32'h1);
    while (!done && cyc < 300) begin
      @(negedge clk); ref_stb = 1'b1; pll_stb = 1'b1; addr = OFF_CMD;
      #1 cyc++;
      if (rdata[0] == 1'b0) done = 1'b1;
    end
    ref_stb = 1'b0; pll_stb = 1'b0;
    check("R8 update latency within bound", int'(cyc <= (lim_of(old_f) + 1) / 2 + 4), 1);
  endtask

  // mode: 0 off, 1 every cycle, 2 random; cs: 0 count ref, 1 count pll, 2 count cycles
  task automatic run(input int mr, input int mp, input int cs, input int s,
                     output int pulses, output int hi, output int samp);
    int cnt = 0;
    bit prev = 1'b0;
    bit done = 1'b0;
    bit r, p;
    pulses = 0; hi = 0; samp = 0;
    while (!done) begin
      @(negedge clk);
      pulses += int'(en);
      if (prev) begin hi += int'(lvl); samp++; end
      if (cnt == s) begin
        ref_stb = 1'b0; pll_stb = 1'b0; done = 1'b1;
      end else begin
        r = (mr == 1) || (mr == 2 && ($urandom % 2) == 1);
        p = (mp == 1) || (mp == 2 && ($urandom % 2) == 1);
        ref_stb = r; pll_stb = p;
        prev = (cs == 0) ? r : (cs == 1) ? p : 1'b0;
        cnt += (cs == 0) ? int'(r) : (cs == 1) ? int'(p) : 1;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int pu, hi, sa, prev_f;
    void'($urandom(32'h5EED1234));
    rst_n = 1'b0; ref_stb = 1'b0; pll_stb = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 enable low after reset", int'(en), 0);
    check("R1 level low after reset", int'(lvl), 0);
    bus_rd(OFF_CFG, d); check("R1 R10 cfg reset", int'(d), 0);
    bus_rd(OFF_CMD, d); check("R1 R10 cmd reset", int'(d), 0);
    bus_rd(OFF_M, d);   check("R1 R10 M reset", int'(d), 0);
    bus_rd(OFF_N, d);   check("R1 R10 N reset", int'(d), 0);
    bus_rd(OFF_D, d);   check("R1 R10 D reset", int'(d), 0);

    // R9 single strobe timing
    @(negedge clk); ref_stb = 1'b1;
    @(negedge clk); ref_stb = 1'b0; check("R9 enable one cycle after strobe", int'(en), 1);
    @(negedge clk); check("R9 enable lasts one cycle", int'(en), 0);

    // R1 default divide by 1 on reference, R6 bypass level
    run(1, 0, 0, 20, pu, hi, sa);
    check("R1 R4 default divide-by-1 pulses", pu, 20);
    check("R6 bypass level equals enable", hi, sa);
    run(0, 1, 2, 30, pu, hi, sa);
    check("R3 unselected pll strobe ignored", pu, 0);

    // R2 R10 masking
    bus_wr(OFF_CFG, 32'hFFFF_FFFF); bus_rd(OFF_CFG, d);
    check("R2 cfg reads bits 13:0 only", int'(d), 32'h3FFF);
    bus_wr(OFF_M, 32'hFFFF_FFFF); bus_rd(OFF_M, d);
    check("R10 M keeps low 16 bits", int'(d), 32'hFFFF);
    bus_wr(OFF_M, 32'h0);

    // R7 shadow write without update
    bus_wr(OFF_CFG, 32'h0000_0007);
    run(1, 2, 0, 40, pu, hi, sa);
    check("R7 shadow config has no effect", pu, 40);
    bus_rd(OFF_CMD, d); check("R8 no update pending", int'(d), 0);
    do_update(1);
    run(1, 2, 0, 40, pu, hi, sa);
    check("R4 field 7 divides by 4", pu, 10);

    // R4 half step on pll, R3 source select
    bus_wr(OFF_CFG, (32'd1 << 8) | 32'd2);
    do_update(7);
    run(2, 2, 1, 60, pu, hi, sa);
    check("R4 R3 field 2 divides pll by 1.5", pu, 40);

    // R5 R6 counter M=3 N=10 2D=10
    bus_wr(OFF_M, 32'd3);
    bus_wr(OFF_N, ~32'd7 & 32'hFFFF);
    bus_wr(OFF_D, ~32'd10 & 32'hFFFF);
    bus_wr(OFF_CFG, (32'd2 << 12) | (32'd1 << 8) | 32'd1);
    do_update(2);
    run(0, 1, 1, 10, pu, hi, sa);
    check("R5 M pulses in N ticks", pu, 3);
    check("R6 level high ticks equal D", hi, 5);
    run(2, 2, 1, 50, pu, hi, sa);
    check("R5 sparse strobes 15 pulses in 50 ticks", pu, 15);

    // R5 mode other than 2 bypasses counter
    bus_wr(OFF_CFG, (32'd1 << 8) | 32'd3);
    do_update(1);
    run(0, 2, 1, 20, pu, hi, sa);
    check("R5 mode 0 bypasses counter", pu, 10);
    check("R6 bypass level equals enable", hi, pu);

    // R5 N register zero bypasses counter
    bus_wr(OFF_N, 32'h0);
    bus_wr(OFF_CFG, (32'd2 << 12) | (32'd1 << 8) | 32'd3);
    do_update(3);
    run(0, 1, 1, 20, pu, hi, sa);
    check("R5 N register zero bypasses counter", pu, 10);

    // R3 reserved source code
    bus_wr(OFF_CFG, (32'd3 << 8) | 32'd1);
    do_update(3);
    run(2, 2, 2, 60, pu, hi, sa);
    check("R3 reserved source gives no pulses", pu, 0);
    bus_wr(OFF_CFG, 32'd1);
    do_update(1);
    run(1, 0, 0, 16, pu, hi, sa);
    check("R3 recovery from reserved source", pu, 16);

    // random programming, R4 R5
    prev_f = 1;
    for (int it = 0; it < 8; it++) begin
      int f, src, cm, mm, nn, lim;
      f   = $urandom % 16;
      src = $urandom % 2;
      cm  = $urandom % 2;
      mm  = 1 + $urandom % 20;
      nn  = mm + 1 + $urandom % 40;
      lim = lim_of(f);
      bus_wr(OFF_M, 32'(mm));
      bus_wr(OFF_N, ~32'(nn - mm) & 32'hFFFF);
      bus_wr(OFF_D, $urandom & 32'hFFFF);
      bus_wr(OFF_CFG, (32'(cm ? 2 : 0) << 12) | (32'(src) << 8) | 32'(f));
      do_update(prev_f);
      run(2, 2, src, nn * lim, pu, hi, sa);
      check(cm ? "R5 random counter pulse count" : "R4 random divider pulse count",
            pu, cm ? 2 * mm : 2 * nn);
      prev_f = f;
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule